// File: doc/BRIEF.md
# Per-Hart Timer and Software Interrupt Unit

This peripheral gives a small multi-hart system one shared 64-bit time counter, a 64-bit compare value for each hart and a software-interrupt flag for each hart. It drives one timer-interrupt line and one software-interrupt line per hart. Software reaches every register through a plain 32-bit register bus. Each request is a single-cycle select with address, write enable and write data. It is answered by a ready pulse one cycle later, with read data on the same cycle.

The counter advances by one on every clock cycle in which the tick-enable input is high. Each hart's timer line is a registered result of comparing its compare value against the live counter. Software can therefore schedule an interrupt by writing the two 32-bit halves of a compare value. Software can raise or clear a software interrupt on any hart by writing bit 0 of that hart's flag word. Three parameters place the three register groups in the address space.

Top module: `hart_timer_ctl`

## Requirements
- R1: A write to address SWI_BASE + 4*h, for hart index h below NUM_HARTS, loads bit 0 of the write data into that hart's software-interrupt line `swIrq[h]`. The remaining data bits are ignored.
- R2: A read of SWI_BASE + 4*h returns the current `swIrq[h]` in bit 0, with bits 31:1 zero.
- R3: Hart h's compare value lives at CMP_BASE + 8*h (bits 31:0) and CMP_BASE + 8*h + 4 (bits 63:32). Writing one half leaves the other half unchanged, and each half reads back what was written.
- R4: `timerIrq[h]` is high in the cycle after any cycle in which compare value h is less than or equal to the counter. A compare value written in the past therefore raises the line one cycle after the write.
- R5: After a compare value greater than the counter is written, `timerIrq[h]` is low. It stays low until the counter equals the value, and it rises on the cycle after that.
- R6: A read of TIME_BASE returns counter bits 31:0, and a read of TIME_BASE + 4 returns bits 63:32, as sampled on the request cycle. Writes to either address do not change the counter.
- R7: The counter adds exactly one on every clock edge where `tickEn` is high and holds otherwise.
- R8: Requests to unmapped addresses, to addresses that are not word aligned inside a register group, or to hart indices at or above NUM_HARTS return zero on a read and change nothing on a write.
- R9: Reset clears the counter, all compare values and all software-interrupt lines. It sets every timer line high, because a compare value of 0 equals a counter of 0.
- R10: `busReady` is high exactly in the cycle after each cycle with `busSel` high, and low otherwise. `busRdata` is zero for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable from the timebase |
| busSel | input | 1 | Request valid for one cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the 32-bit word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Request completion pulse |
| timerIrq | output | NUM_HARTS | Timer interrupt per hart |
| swIrq | output | NUM_HARTS | Software interrupt per hart |

## Verification
The assertions assume that `busSel` is a one-cycle pulse per request and that the three register groups do not overlap. The bench only issues single-cycle requests separated by an idle cycle, and it uses the default bases, which keep the groups apart. The bench holds `tickEn` low during every bus-driven check, so expected counter values are fixed by counting only the edges on which the bench raises it.

// File: rtl/htc_pkg.sv
package htc_pkg;
  typedef enum logic [2:0] {
    RD_NONE,
    RD_SWI,
    RD_CMP_LO,
    RD_CMP_HI,
    RD_TIME_LO,
    RD_TIME_HI
  } rdSel_e;

  typedef struct packed {
    logic       swiWr;
    logic       cmpLoWr;
    logic       cmpHiWr;
    rdSel_e     rdSel;
    logic [7:0] hart;
  } strobe_t;
endpackage

// File: rtl/htc_ctl.sv
module htc_ctl
  import htc_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SWI_BASE  = 'h0000,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 'h4000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 'hBFF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output logic              busReady
);
  localparam logic [ADDR_W-1:0] SWI_SPAN  = ADDR_W'(4 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] CMP_SPAN  = ADDR_W'(8 * NUM_HARTS);
  localparam logic [ADDR_W-1:0] TIME_HIGH = TIME_BASE + ADDR_W'(4);

  logic [ADDR_W-1:0] swiOff, cmpOff;
  logic              swiHit, cmpHit, timeLoHit, timeHiHit;

  always_comb begin
    swiOff    = busAddr - SWI_BASE;
    cmpOff    = busAddr - CMP_BASE;
    swiHit    = (busAddr >= SWI_BASE) && (swiOff < SWI_SPAN) && (swiOff[1:0] == 2'b00);
    cmpHit    = (busAddr >= CMP_BASE) && (cmpOff < CMP_SPAN) && (cmpOff[1:0] == 2'b00);
    timeLoHit = (busAddr == TIME_BASE);
    timeHiHit = (busAddr == TIME_HIGH);
  end

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (swiHit) begin
      stb.hart = 8'(swiOff >> 2);
    end else if (cmpHit) begin
      stb.hart = 8'(cmpOff >> 3);
    end
    if (busSel && busWe) begin
      stb.swiWr   = swiHit;
      stb.cmpLoWr = !swiHit && cmpHit && !cmpOff[2];
      stb.cmpHiWr = !swiHit && cmpHit && cmpOff[2];
    end else if (busSel) begin
      if (swiHit)         stb.rdSel = RD_SWI;
      else if (cmpHit)    stb.rdSel = cmpOff[2] ? RD_CMP_HI : RD_CMP_LO;
      else if (timeLoHit) stb.rdSel = RD_TIME_LO;
      else if (timeHiHit) stb.rdSel = RD_TIME_HI;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busReady <= 1'b0;
    else       busReady <= busSel;
  end
endmodule

// File: rtl/htc_datapath.sv
module htc_datapath
  import htc_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tickEn,
  input  strobe_t                       stb,
  input  logic [DATA_W-1:0]             busWdata,
  output logic [DATA_W-1:0]             busRdata,
  output logic [NUM_HARTS-1:0]          timerIrq,
  output logic [NUM_HARTS-1:0]          swIrq,
  output logic [2*DATA_W-1:0]           timeNow,
  output logic [NUM_HARTS*2*DATA_W-1:0] cmpFlat
);
  localparam int unsigned TIME_W = 2 * DATA_W;
  localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic [TIME_W-1:0] timeCnt;
  logic [TIME_W-1:0] cmpReg [NUM_HARTS];
  logic [HART_W-1:0] hIdx;
  logic [DATA_W-1:0] rdNext;

  assign hIdx    = stb.hart[HART_W-1:0];
  assign timeNow = timeCnt;

  always_ff @(posedge clk) begin
    if (!rstN)       timeCnt <= '0;
    else if (tickEn) timeCnt <= timeCnt + TIME_W'(1);
  end

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    logic selThis;
    assign selThis = (stb.hart == 8'(h));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg[h] <= '0;
        swIrq[h]  <= 1'b0;
      end else begin
        if (stb.cmpLoWr && selThis) cmpReg[h][DATA_W-1:0]      <= busWdata;
        if (stb.cmpHiWr && selThis) cmpReg[h][TIME_W-1:DATA_W] <= busWdata;
        if (stb.swiWr && selThis)   swIrq[h] <= busWdata[0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) timerIrq[h] <= 1'b1;
      else       timerIrq[h] <= (cmpReg[h] <= timeCnt);
    end

    assign cmpFlat[h*TIME_W +: TIME_W] = cmpReg[h];
  end

  always_comb begin
    rdNext = '0;
    case (stb.rdSel)
      RD_SWI:     rdNext = DATA_W'(swIrq[hIdx]);
      RD_CMP_LO:  rdNext = cmpReg[hIdx][DATA_W-1:0];
      RD_CMP_HI:  rdNext = cmpReg[hIdx][TIME_W-1:DATA_W];
      RD_TIME_LO: rdNext = timeCnt[DATA_W-1:0];
      RD_TIME_HI: rdNext = timeCnt[TIME_W-1:DATA_W];
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end
endmodule

// File: rtl/hart_timer_ctl.sv
module hart_timer_ctl
  import htc_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SWI_BASE  = 'h0000,
  parameter logic [ADDR_W-1:0] CMP_BASE  = 'h4000,
  parameter logic [ADDR_W-1:0] TIME_BASE = 'hBFF8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 busSel,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  output logic                 busReady,
  output logic [NUM_HARTS-1:0] timerIrq,
  output logic [NUM_HARTS-1:0] swIrq
);
  strobe_t                stb;
  logic [63:0]            timeNow;
  logic [NUM_HARTS*64-1:0] cmpFlat;

  htc_ctl #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W),
    .SWI_BASE(SWI_BASE), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .stb(stb), .busReady(busReady)
  );

  htc_datapath #(.NUM_HARTS(NUM_HARTS), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb),
    .busWdata(busWdata), .busRdata(busRdata), .timerIrq(timerIrq),
    .swIrq(swIrq), .timeNow(timeNow), .cmpFlat(cmpFlat)
  );
endmodule

// File: rtl/hart_timer_ctl_chk.sv
module hart_timer_ctl_chk #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SWI_BASE = 'h0000
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    tickEn,
  input logic                    busSel,
  input logic                    busWe,
  input logic [ADDR_W-1:0]       busAddr,
  input logic [31:0]             busWdata,
  input logic [31:0]             busRdata,
  input logic                    busReady,
  input logic [NUM_HARTS-1:0]    timerIrq,
  input logic [NUM_HARTS-1:0]    swIrq,
  input logic [63:0]             timeNow,
  input logic [NUM_HARTS*64-1:0] cmpFlat
);
  // R10
  ready_follows_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel |=> busReady);
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> !busReady);
  // R7
  time_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> timeNow == $past(timeNow) + 64'd1);
  // R7
  time_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timeNow));
  // R1
  swi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWe && busAddr == SWI_BASE) |=> swIrq[0] == $past(busWdata[0]));
  // R8
  beyond_harts_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == SWI_BASE + ADDR_W'(4 * NUM_HARTS)) |=> busRdata == 32'd0);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_irq
    // R4
    timer_level_chk: assert property (@(posedge clk) disable iff (!rstN)
      rstN |=> timerIrq[h] == $past(cmpFlat[h*64 +: 64] <= timeNow));
  end
endmodule

bind hart_timer_ctl hart_timer_ctl_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .SWI_BASE(SWI_BASE)
) u_chk (.*);

// File: tb/sim_hart_timer_ctl.sv
`timescale 1ns/1ps
module sim_hart_timer_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWe = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [3:0]  timerIrq;
  logic [3:0]  swIrq;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  hart_timer_ctl u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busReady(busReady), .timerIrq(timerIrq), .swIrq(swIrq)
  );

  // fields: we, checkRead, addr[15:0], wdata[31:0], expected[31:0]
  localparam int NV = 19;
  localparam logic [81:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h0000, 32'h0,          32'h0},
    {1'b1, 1'b0, 16'h0004, 32'h1,          32'h0},
    {1'b0, 1'b1, 16'h0004, 32'h0,          32'h1},
    {1'b1, 1'b0, 16'h0004, 32'hFFFF_FFFE,  32'h0},
    {1'b0, 1'b1, 16'h0004, 32'h0,          32'h0},
    {1'b1, 1'b0, 16'h4010, 32'h1234_5678,  32'h0},
    {1'b1, 1'b0, 16'h4014, 32'h0000_00AB,  32'h0},
    {1'b0, 1'b1, 16'h4010, 32'h0,          32'h1234_5678},
    {1'b0, 1'b1, 16'h4014, 32'h0,          32'h0000_00AB},
    {1'b1, 1'b0, 16'h4010, 32'h9,          32'h0},
    {1'b0, 1'b1, 16'h4014, 32'h0,          32'h0000_00AB},
    {1'b0, 1'b1, 16'h4010, 32'h0,          32'h9},
    {1'b0, 1'b1, 16'h4001, 32'h0,          32'h0},
    {1'b1, 1'b0, 16'h0010, 32'h1,          32'h0},
    {1'b0, 1'b1, 16'h0010, 32'h0,          32'h0},
    {1'b0, 1'b1, 16'h8000, 32'h0,          32'h0},
    {1'b1, 1'b0, 16'h000C, 32'h3,          32'h0},
    {1'b0, 1'b1, 16'h000C, 32'h0,          32'h1},
    {1'b1, 1'b0, 16'h000C, 32'h0,          32'h0}
  };
  localparam string TAG [NV] = '{
    "R2", "R1", "R2", "R1", "R2", "R3", "R3", "R3", "R3", "R3",
    "R3", "R3", "R8", "R8", "R8", "R8", "R1", "R2", "R1"
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic rdy);
    busSel = 1'b1; busWe = we; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
    rd = busRdata; rdy = busReady;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic        rdy;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", 64'(timerIrq), 64'hF);
    check("R9", 64'(swIrq), 64'h0);
    check("R10", 64'(busReady), 64'h0);
    access(1'b0, 16'hBFF8, 32'h0, rd, rdy);
    check("R9", 64'(rd), 64'h0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][81], VEC[i][79:64], VEC[i][63:32], rd, rdy);
      check("R10", 64'(rdy), 64'h1);
      if (VEC[i][80]) check(TAG[i], 64'(rd), 64'(VEC[i][31:0]));
      else            check("R10", 64'(rd), 64'h0);
      @(negedge clk);
      check("R10", 64'(busReady), 64'h0);
    end
    check("R8", 64'(swIrq), 64'h0);

    // R7 counter advance
    ticks(10);
    access(1'b0, 16'hBFF8, 32'h0, rd, rdy);
    check("R7", 64'(rd), 64'd10);
    access(1'b0, 16'hBFFC, 32'h0, rd, rdy);
    check("R6", 64'(rd), 64'd0);
    // R6 writes to time ignored
    access(1'b1, 16'hBFF8, 32'hFFFF, rd, rdy);
    access(1'b1, 16'hBFFC, 32'h5, rd, rdy);
    access(1'b0, 16'hBFF8, 32'h0, rd, rdy);
    check("R6", 64'(rd), 64'd10);
    access(1'b0, 16'hBFFC, 32'h0, rd, rdy);
    check("R6", 64'(rd), 64'd0);

    // R5 future compare on hart 0
    access(1'b1, 16'h4000, 32'd20, rd, rdy);
    @(negedge clk);
    check("R5", 64'(timerIrq[0]), 64'h0);
    ticks(9);
    check("R5", 64'(timerIrq[0]), 64'h0);
    ticks(1);
    check("R5", 64'(timerIrq[0]), 64'h0);
    @(negedge clk);
    check("R5", 64'(timerIrq[0]), 64'h1);

    // R4 hart 1 past / future / past
    access(1'b1, 16'h4008, 32'd5, rd, rdy);
    @(negedge clk);
    check("R4", 64'(timerIrq[1]), 64'h1);
    access(1'b1, 16'h400C, 32'd1, rd, rdy);
    @(negedge clk);
    check("R4", 64'(timerIrq[1]), 64'h0);
    access(1'b1, 16'h400C, 32'd0, rd, rdy);
    @(negedge clk);
    check("R4", 64'(timerIrq[1]), 64'h1);
    check("R4", 64'(timerIrq[2]), 64'h0);

    // R9 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", 64'(timerIrq), 64'hF);
    access(1'b0, 16'h4010, 32'h0, rd, rdy);
    check("R9", 64'(rd), 64'h0);
    access(1'b0, 16'hBFF8, 32'h0, rd, rdy);
    check("R9", 64'(rd), 64'h0);

    finishRun();
  end
endmodule